// File: doc/BRIEF.md
# CAN Bus-Join Controller

This block sits between the host register file and the protocol engine of a stand-alone CAN controller. It owns the reset-request flag and decides when the node may take part in bus traffic again. It has three sources of reset. The first is a hardware reset pin. The second is a host write of the request bit. The third is a bus-off indication from the error counters, which forces the request on. While the request is set, the block holds the protocol engine in reset mode, and that aborts any frame in progress.

When the host clears the request, the block does not rejoin the bus at once. It waits for the bus to go idle a required number of times. One idle period is eleven recessive bits in a row, each sampled on a bit-time strobe. The required number of idle periods depends on what caused the reset, and the cause is latched when reset mode is entered. A hardware reset or a host reset needs one idle period. A bus-off needs 128. Everything runs on the internal clock, which is the oscillator divided by two. The host reads back the registered request flag, not the value it last wrote.

Top module: `can_busjoin_ctrl`

## Requirements
- R1: An idle period is counted when 11 consecutive strobed bits are recessive (`rx_bit_i`=1). A strobed dominant bit (`rx_bit_i`=0) restarts the recessive run. Idle periods already counted are kept.
- R2: If the last reset came from the hardware pin or from a host write of 1, `bus_on_o` rises on the clock edge that ends the first idle period after the request is cleared.
- R3: If the last reset came from bus-off, `bus_on_o` rises only on the clock edge that ends the 128th idle period after the request is cleared.
- R4: While `bus_off_i` is 1, `rst_req_o` is 1 after the next clock edge, whatever the host writes in that cycle.
- R5: While `rst_ni` is low, `rst_req_o` and `reset_mode_o` read 1 and `bus_on_o` reads 0. A host write of 0 in that time has no effect.
- R6: A host write (`host_wr_en_i`=1) sets the request to `host_wr_req_i` at the next rising clock edge. `rst_req_o` always shows this registered value.
- R7: `reset_mode_o` follows `rst_req_o`. Whenever it is 1, `bus_on_o` is 0.
- R8: Setting the request again during the idle wait cancels the wait and clears both the run count and the idle-period count. After the next clear, the full count is needed again.
- R9: Recessive bits strobed while the request is set do not count toward the idle wait.
- R10: Receive bits that arrive without `bit_strobe_i` are ignored.
- R11: While bus-on, a bus-off or a host write of 1 drops `bus_on_o` after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock (oscillator / 2) |
| rst_ni | input | 1 | External hardware reset pin, active low |
| host_wr_en_i | input | 1 | Host write strobe for the request bit |
| host_wr_req_i | input | 1 | Request value written by the host |
| bus_off_i | input | 1 | Bus-off status from the error-counter logic |
| rx_bit_i | input | 1 | Sampled receive bit, 1 = recessive |
| bit_strobe_i | input | 1 | One-cycle pulse marking a valid sampled bit |
| rst_req_o | output | 1 | Registered reset-request status for host readback |
| reset_mode_o | output | 1 | Holds the protocol engine in reset, aborting frames |
| bus_on_o | output | 1 | Node is active on the bus |

## Verification
The hardest situation to reach is the long bus-off wait. It needs 1408 strobed recessive bits with no reset request in between. Random traffic with dominant bits mixed in almost never gets there. A directed sequence feeds exactly 127 full idle periods, checks that the node is still off, and then completes the last period. The cancel-and-restart case (setting the request again partway through a run) and a hardware reset applied mid-run are also driven directly. Long random stretches then mix host writes, brief bus-off pulses, strobe gaps and dominant bits, and a cycle-level bench model checks every cycle.

// File: rtl/can_bj_pkg.sv
package can_bj_pkg;

  typedef enum logic [1:0] {
    JS_HALT = 2'd0,
    JS_WAIT = 2'd1,
    JS_ON   = 2'd2
  } join_state_e;

  typedef enum logic {
    CAUSE_HOST   = 1'b0,
    CAUSE_BUSOFF = 1'b1
  } reset_cause_e;

endpackage

// File: rtl/can_bj_rst_sync.sv
module can_bj_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  // Assertion is asynchronous, release walks through STAGES flops.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/can_bj_req_reg.sv
module can_bj_req_reg
  import can_bj_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic         wr_val_i,
  input  logic         bus_off_i,
  output logic         req_o,
  output reset_cause_e cause_o
);

  logic         req_q, req_d;
  reset_cause_e cause_q, cause_d;

  // Bus-off overrides the host. A fresh host request marks the cause as host.
  always_comb begin
    req_d   = req_q;
    cause_d = cause_q;
    if (bus_off_i) begin
      req_d   = 1'b1;
      cause_d = CAUSE_BUSOFF;
    end else if (wr_en_i) begin
      req_d = wr_val_i;
      if (wr_val_i && !req_q) begin
        cause_d = CAUSE_HOST;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b1;
      cause_q <= CAUSE_HOST;
    end else begin
      req_q   <= req_d;
      cause_q <= cause_d;
    end
  end

  assign req_o   = req_q;
  assign cause_o = cause_q;

endmodule

// File: rtl/can_bj_idle_cnt.sv
module can_bj_idle_cnt #(
  parameter int FREE_BITS = 11,
  parameter int MAX_OCC   = 128,
  localparam int RUN_W = $clog2(FREE_BITS + 1),
  localparam int OCC_W = $clog2(MAX_OCC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             strobe_i,
  input  logic             rx_i,
  input  logic [OCC_W-1:0] target_i,
  output logic             done_o
);

  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(FREE_BITS - 1);

  logic [RUN_W-1:0] run_q, run_d;
  logic [OCC_W-1:0] occ_q, occ_d, occ_inc;
  logic             tick, run_full;

  assign tick     = en_i & strobe_i;
  assign run_full = (run_q == RUN_LAST);
  assign occ_inc  = occ_q + 1'b1;

  always_comb begin
    run_d  = run_q;
    occ_d  = occ_q;
    done_o = 1'b0;
    if (clr_i) begin
      run_d = '0;
      occ_d = '0;
    end else if (tick) begin
      if (!rx_i) begin
        run_d = '0;
      end else if (run_full) begin
        run_d  = '0;
        occ_d  = occ_inc;
        done_o = (occ_inc == target_i);
      end else begin
        run_d = run_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      occ_q <= '0;
    end else begin
      run_q <= run_d;
      occ_q <= occ_d;
    end
  end

endmodule

// File: rtl/can_busjoin_ctrl.sv
module can_busjoin_ctrl
  import can_bj_pkg::*;
#(
  parameter int FREE_BITS   = 11,
  parameter int HOST_WAIT   = 1,
  parameter int BUSOFF_WAIT = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic host_wr_en_i,
  input  logic host_wr_req_i,
  input  logic bus_off_i,
  input  logic rx_bit_i,
  input  logic bit_strobe_i,
  output logic rst_req_o,
  output logic reset_mode_o,
  output logic bus_on_o
);

  localparam int MAX_OCC = (BUSOFF_WAIT > HOST_WAIT) ? BUSOFF_WAIT : HOST_WAIT;
  localparam int OCC_W   = $clog2(MAX_OCC + 1);
  localparam logic [OCC_W-1:0] HOST_T   = OCC_W'(HOST_WAIT);
  localparam logic [OCC_W-1:0] BUSOFF_T = OCC_W'(BUSOFF_WAIT);

  logic         rst_sync_n;
  logic         req_q;
  reset_cause_e cause_q;
  join_state_e  state_q, state_d;
  logic         cnt_clr, cnt_en, idle_done;
  logic [OCC_W-1:0] target;

  can_bj_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  can_bj_req_reg u_req (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .wr_en_i   (host_wr_en_i),
    .wr_val_i  (host_wr_req_i),
    .bus_off_i (bus_off_i),
    .req_o     (req_q),
    .cause_o   (cause_q)
  );

  assign target  = (cause_q == CAUSE_BUSOFF) ? BUSOFF_T : HOST_T;
  assign cnt_clr = req_q | (state_q == JS_ON);
  assign cnt_en  = (state_q != JS_ON);

  can_bj_idle_cnt #(.FREE_BITS(FREE_BITS), .MAX_OCC(MAX_OCC)) u_idle (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .clr_i    (cnt_clr),
    .en_i     (cnt_en),
    .strobe_i (bit_strobe_i),
    .rx_i     (rx_bit_i),
    .target_i (target),
    .done_o   (idle_done)
  );

  always_comb begin
    state_d = state_q;
    if (req_q) begin
      state_d = JS_HALT;
    end else begin
      case (state_q)
        JS_HALT: state_d = idle_done ? JS_ON : JS_WAIT;
        JS_WAIT: if (idle_done) state_d = JS_ON;
        JS_ON:   state_d = JS_ON;
        default: state_d = JS_HALT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= JS_HALT;
    end else begin
      state_q <= state_d;
    end
  end

  assign rst_req_o    = req_q;
  assign reset_mode_o = req_q;
  assign bus_on_o     = (state_q == JS_ON) & ~req_q;

endmodule

// File: rtl/can_busjoin_ctrl_chk.sv
module can_busjoin_ctrl_chk #(
  parameter int FREE_BITS = 11
) (
  input logic clk_i,
  input logic rst_ni,
  input logic host_wr_en_i,
  input logic host_wr_req_i,
  input logic bus_off_i,
  input logic rx_bit_i,
  input logic bit_strobe_i,
  input logic rst_req_o,
  input logic bus_on_o
);

  localparam int CW = $clog2(FREE_BITS + 2);
  localparam logic [CW-1:0] SAT = CW'(FREE_BITS + 1);

  // Strobes seen since the request was last set, saturating.
  logic [CW-1:0] strobes_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobes_q <= '0;
    end else if (rst_req_o) begin
      strobes_q <= '0;
    end else if (bit_strobe_i && (strobes_q != SAT)) begin
      strobes_q <= strobes_q + 1'b1;
    end
  end

  assert_busoff_forces_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_off_i |=> rst_req_o);

  assert_host_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_en_i && !host_wr_req_i && !bus_off_i) |=> !rst_req_o);

  assert_host_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_en_i && host_wr_req_i) |=> rst_req_o);

  assert_on_after_recessive_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_on_o) |-> $past(rx_bit_i && bit_strobe_i));

  assert_dominant_blocks_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_strobe_i && !rx_bit_i && !bus_on_o) |=> !bus_on_o);

  assert_min_wait_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_on_o) |-> (strobes_q >= CW'(FREE_BITS)));

  assert_no_instant_on_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_req_o) |-> !bus_on_o);

  assert_leave_on_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_on_o && bus_off_i) |=> !bus_on_o);

endmodule

bind can_busjoin_ctrl can_busjoin_ctrl_chk #(.FREE_BITS(FREE_BITS)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_sync_n),
  .host_wr_en_i  (host_wr_en_i),
  .host_wr_req_i (host_wr_req_i),
  .bus_off_i     (bus_off_i),
  .rx_bit_i      (rx_bit_i),
  .bit_strobe_i  (bit_strobe_i),
  .rst_req_o     (rst_req_o),
  .bus_on_o      (bus_on_o)
);

// File: tb/can_busjoin_ctrl_tb_top.sv
`timescale 1ns/1ps
module can_busjoin_ctrl_tb_top;

  localparam int RUN_BITS   = 11;
  localparam int HOST_N     = 1;
  localparam int BUSOFF_N   = 128;
  localparam int MAX_CYCLES = 200000;

  logic clk_i = 1'b0;
  logic rst_ni, host_wr_en_i, host_wr_req_i, bus_off_i, rx_bit_i, bit_strobe_i;
  logic rst_req_o, reset_mode_o, bus_on_o;

  always #10 clk_i = ~clk_i;

  can_busjoin_ctrl dut_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .host_wr_en_i  (host_wr_en_i),
    .host_wr_req_i (host_wr_req_i),
    .bus_off_i     (bus_off_i),
    .rx_bit_i      (rx_bit_i),
    .bit_strobe_i  (bit_strobe_i),
    .rst_req_o     (rst_req_o),
    .reset_mode_o  (reset_mode_o),
    .bus_on_o      (bus_on_o)
  );

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  // Bench model of the requirements.
  bit m_req, m_busoff_cause, m_on;
  int m_run, m_occ, m_rel;

  function automatic void model_reset();
    m_req = 1'b1; m_busoff_cause = 1'b0; m_on = 1'b0; m_run = 0; m_occ = 0;
  endfunction

  function automatic int need_count();
    return m_busoff_cause ? BUSOFF_N : HOST_N;
  endfunction

  function automatic void model_edge(bit wr, bit val, bit bo, bit stb, bit rx);
    bit n_req, n_cause;
    if (!rst_ni) begin
      m_rel = 0; model_reset(); return;
    end
    if (m_rel < 2) begin
      m_rel++; model_reset(); return;
    end
    n_req = m_req; n_cause = m_busoff_cause;
    if (bo) begin n_req = 1'b1; n_cause = 1'b1; end
    else if (wr) begin
      n_req = val;
      if (val && !m_req) n_cause = 1'b0;
    end
    if (m_req) begin
      m_on = 1'b0; m_run = 0; m_occ = 0;
    end else if (!m_on && stb) begin
      if (!rx) m_run = 0;
      else if (m_run == RUN_BITS - 1) begin
        m_run = 0; m_occ++;
        if (m_occ == need_count()) begin m_on = 1'b1; m_occ = 0; end
      end else m_run++;
    end
    m_req = n_req; m_busoff_cause = n_cause;
  endfunction

  task automatic chk(input logic got, input logic exp, input string what, input string tag);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic step(input bit wr, input bit val, input bit bo, input bit stb,
                      input bit rx, input string tag);
    host_wr_en_i = wr; host_wr_req_i = val; bus_off_i = bo;
    bit_strobe_i = stb; rx_bit_i = rx;
    @(posedge clk_i);
    model_edge(wr, val, bo, stb, rx);
    @(negedge clk_i);
    chk(rst_req_o,    m_req,             "rst_req_o",    tag);
    chk(reset_mode_o, m_req,             "reset_mode_o", tag);
    chk(bus_on_o,     m_on && !m_req,    "bus_on_o",     tag);
  endtask

  task automatic recessive(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 1, 1, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 1, "idle");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #(20.0 * MAX_CYCLES);
    fails++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = 32'h5eed_0c4a;
    void'($urandom(seed));
    m_rel = 0; model_reset();
    rst_ni = 1'b0; host_wr_en_i = 0; host_wr_req_i = 0; bus_off_i = 0;
    rx_bit_i = 1; bit_strobe_i = 0;
    @(negedge clk_i);

    // R5: pin low, write of 0 ignored
    step(1, 0, 0, 1, 1, "R5");
    chk(rst_req_o, 1'b1, "rst_req_o literal", "R5");
    chk(bus_on_o, 1'b0, "bus_on_o literal", "R5");
    rst_ni = 1'b1;
    idle(3);

    // R6 / R7: host clear takes effect at next edge
    step(1, 0, 0, 0, 1, "R6");
    chk(rst_req_o, 1'b0, "rst_req_o literal", "R6");
    chk(reset_mode_o, 1'b0, "reset_mode_o literal", "R7");

    // R1 / R2: dominant restarts run, one idle period then bus-on
    recessive(10, "R1");
    chk(bus_on_o, 1'b0, "bus_on_o before 11th", "R1");
    step(0, 0, 0, 1, 0, "R1");
    recessive(10, "R1");
    chk(bus_on_o, 1'b0, "bus_on_o after restart", "R1");
    recessive(1, "R2");
    chk(bus_on_o, 1'b1, "bus_on_o host cause", "R2");

    // R4 / R11: bus-off forces request and drops bus-on
    step(0, 0, 1, 0, 1, "R4");
    chk(rst_req_o, 1'b1, "rst_req_o after bus-off", "R4");
    chk(bus_on_o, 1'b0, "bus_on_o after bus-off", "R11");
    step(1, 0, 1, 0, 1, "R4");
    chk(rst_req_o, 1'b1, "write 0 under bus-off", "R4");

    // R3: 128 idle periods after bus-off
    step(1, 0, 0, 0, 1, "R3");
    recessive(127 * RUN_BITS, "R3");
    chk(bus_on_o, 1'b0, "bus_on_o after 127 periods", "R3");
    recessive(RUN_BITS, "R3");
    chk(bus_on_o, 1'b1, "bus_on_o after 128 periods", "R3");

    // R11: host set while bus-on
    step(1, 1, 0, 0, 1, "R11");
    chk(bus_on_o, 1'b0, "bus_on_o after host set", "R11");

    // R8: re-request mid-wait clears counters
    step(1, 0, 0, 0, 1, "R8");
    recessive(8, "R8");
    step(1, 1, 0, 0, 1, "R8");
    step(1, 0, 0, 0, 1, "R8");
    recessive(10, "R8");
    chk(bus_on_o, 1'b0, "bus_on_o after cancel", "R8");
    recessive(1, "R8");
    chk(bus_on_o, 1'b1, "bus_on_o full count", "R8");

    // R9: strobes while request set do not count
    step(1, 1, 0, 0, 1, "R9");
    recessive(30, "R9");
    step(1, 0, 0, 0, 1, "R9");
    chk(bus_on_o, 1'b0, "bus_on_o at clear", "R9");
    recessive(10, "R9");
    chk(bus_on_o, 1'b0, "bus_on_o 10 bits", "R9");
    recessive(1, "R9");
    chk(bus_on_o, 1'b1, "bus_on_o 11 bits", "R9");

    // R10: unstrobed dominant bits ignored
    step(1, 1, 0, 0, 1, "R10");
    step(1, 0, 0, 0, 1, "R10");
    recessive(5, "R10");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, "R10");
    recessive(5, "R10");
    chk(bus_on_o, 1'b0, "bus_on_o 10 strobed", "R10");
    recessive(1, "R10");
    chk(bus_on_o, 1'b1, "bus_on_o run kept", "R10");

    // R5 mid-run and R2 after hardware reset
    rst_ni = 1'b0;
    step(1, 0, 0, 1, 1, "R5");
    chk(rst_req_o, 1'b1, "rst_req_o pin low", "R5");
    chk(bus_on_o, 1'b0, "bus_on_o pin low", "R5");
    rst_ni = 1'b1;
    idle(3);
    step(1, 0, 0, 0, 1, "R2");
    recessive(RUN_BITS, "R2");
    chk(bus_on_o, 1'b1, "bus_on_o after hw reset", "R2");

    // Constrained random traffic, every cycle against the model
    for (int i = 0; i < 20000; i++) begin
      bit wr, val, bo, stb, rx;
      wr  = ($urandom_range(199) == 0);
      val = ($urandom_range(3) == 0);
      bo  = ($urandom_range(1999) == 0);
      stb = ($urandom_range(1) == 0);
      rx  = ($urandom_range(15) != 0);
      if (!wr && m_req && !bo && $urandom_range(19) == 0) begin
        wr = 1'b1; val = 1'b0;
      end
      step(wr, val, bo, stb, rx, "R1 R6 R7 random");
    end

    finish_run();
  end

endmodule